// File: doc/BRIEF.md
# Event-Timer Register File

This block is the memory-mapped register interface of a multi-channel event timer. It decodes 32-bit and 64-bit reads and writes to four global registers: capability, configuration, interrupt status and main counter. It also decodes three registers per channel: configuration, comparator and route. Read data is combinational from the address presented in the same cycle. A write takes effect at the clock edge that ends its cycle.

Comparator matching is done outside the block. The external expiry logic raises one `ch_fire` bit per expiring channel for a single cycle. The register file turns that event into a status bit and an interrupt line. A channel in level mode latches its status bit and holds its line while the channel and the whole timer are enabled. A channel in edge mode emits a one-cycle pulse. The route register is stored and read back only.

The main counter advances by one every clock while the global enable is set. It holds its value while the global enable is clear. Software can write it in either 32-bit half or as a whole.

Top module: `evt_regfile`

## Requirements
- R1: Register map. Global registers sit at 0x000 (capability), 0x010 (configuration), 0x020 (status) and 0x0F0 (main counter). Channel n has its base at 0x100 + 0x20·n, with configuration at +0x0, comparator at +0x8 and route at +0x10. After reset the following reads hold. Capability returns the tick period in [63:32], 1 in bit 13, NUM_CH-1 in [12:8] and the revision in [7:0]. Global configuration and status read 0. Each comparator reads all ones. Channel configuration reads only its read-only bits. Reads of +0x18, of channels at or above NUM_CH, and of any other unmapped offset return 0.
- R2: Access width. A 4-byte write with address bit 2 clear replaces bits [31:0]. A 4-byte write with address bit 2 set replaces bits [63:32] from the low 32 data bits. An 8-byte write with bit 2 clear replaces all 64 bits. A read with address bit 2 set returns the register shifted right by 32.
- R3: Read-only protection. Channel configuration bits 1 (level mode), 2 (interrupt enable), 3 (periodic) and 8 (32-bit mode) are writable. Bit 5 always reads 1. Bits [63:32] always read the ROUTE_CAP parameter. All other channel configuration bits read 0. In global configuration only bit 0 (global enable) is writable. Writes to capability have no effect.
- R4: Writing status clears each bit n written as 1 and drops channel n's level interrupt. Bits written as 0 are unchanged. A write to the upper status half clears nothing.
- R5: An expiry on a level-mode channel sets its status bit even when the channel enable or the global enable is 0. In that case the channel's line stays low.
- R6: A level-mode channel with status set drives its line high in the cycle after both its channel enable and the global enable are 1. This holds whether the channel enable or the global enable rose last.
- R7: Writing a level-mode channel to edge mode clears its status bit and lowers its line. Clearing a channel's enable lowers its line but keeps its status bit.
- R8: An expiry on an enabled edge-mode channel, with the global enable set, drives a one-cycle pulse in the next cycle and leaves the status bit clear. With the channel disabled there is no pulse.
- R9: The main counter increments by one per clock while the global enable is 1 and holds otherwise. Writes follow R2 and take priority over counting. The count carries across bit 32.
- R10: With 32-bit mode set, a write to the upper comparator half is ignored. A lower-half write, 4-byte or 8-byte, zero-extends into all 64 bits. Setting 32-bit mode clears the stored comparator's upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 64 | Write data, low 32 bits used by 4-byte writes |
| bus_rdata | output | 64 | Read data, zero when no read is in progress |
| ch_fire | input | NUM_CH | One-cycle expiry event per channel |
| ch_irq | output | NUM_CH | Interrupt line per channel |

## Verification
The bench builds the block with four channels, a 10-bit address, and distinct non-zero revision, tick period and route capability values. This makes every capability field and every read-only configuration bit visible as a non-trivial pattern. Four channels are enough to probe an offset just past the last channel, to show that an upper-half status write hits no channel, and to run two level channels together while a third sits in edge mode. The counter is preset just below a 32-bit boundary, so a few cycles of counting expose a missing carry into the upper half.

// File: rtl/evt_pkg.sv
package evt_pkg;

   localparam int unsigned REG_W  = 64;
   localparam int unsigned HALF_W = 32;

   // per-channel register select, taken from address bits [4:3]
   typedef enum logic [1:0] {
      CH_CFG   = 2'd0,
      CH_CMP   = 2'd1,
      CH_ROUTE = 2'd2,
      CH_HOLE  = 2'd3
   } ch_reg_e;

   typedef enum logic [2:0] {
      G_CAP,
      G_CFG,
      G_STS,
      G_CNT,
      G_HOLE
   } glb_reg_e;

   // channel configuration bit positions
   localparam int unsigned CB_LVL   = 1;
   localparam int unsigned CB_IEN   = 2;
   localparam int unsigned CB_PER   = 3;
   localparam int unsigned CB_CAP64 = 5;
   localparam int unsigned CB_W32   = 8;

   localparam logic [REG_W-1:0] CH_WMASK =
      (64'd1 << CB_LVL) | (64'd1 << CB_IEN) | (64'd1 << CB_PER) | (64'd1 << CB_W32);

   localparam int unsigned      GB_EN     = 0;
   localparam logic [REG_W-1:0] GLB_WMASK = 64'd1 << GB_EN;

   // fold a 4- or 8-byte write into a 64-bit register
   function automatic logic [REG_W-1:0] merge64(input logic [REG_W-1:0] old,
                                                input logic [REG_W-1:0] wdata,
                                                input logic             hi,
                                                input logic             wide);
      logic [REG_W-1:0] res;
      if (hi)
         res = {wdata[HALF_W-1:0], old[HALF_W-1:0]};
      else if (wide)
         res = wdata;
      else
         res = {old[REG_W-1:HALF_W], wdata[HALF_W-1:0]};
      return res;
   endfunction

   // keep bits outside the writable mask at their old value
   function automatic logic [REG_W-1:0] keep_ro(input logic [REG_W-1:0] merged,
                                                input logic [REG_W-1:0] old,
                                                input logic [REG_W-1:0] mask);
      return (merged & mask) | (old & ~mask);
   endfunction

endpackage

// File: rtl/evt_addr_dec.sv
module evt_addr_dec
   import evt_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned NUM_CH = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hi,
   output logic              glb_hit,
   output glb_reg_e          glb_sel,
   output logic [NUM_CH-1:0] ch_hit,
   output ch_reg_e           ch_sel
);

   localparam int unsigned SLOT_W    = 5;
   localparam logic [SLOT_W-1:0] CH_FIRST_SLOT = 5'd8;  // 0x100 / 0x20

   logic              upper_clear;
   logic              in_ch_win;
   logic [SLOT_W-1:0] ch_idx;
   logic              unused_lo;

   generate
      if (ADDR_W > 10) begin : g_wide_addr
         assign upper_clear = ~|addr[ADDR_W-1:10];
      end else begin : g_exact_addr
         assign upper_clear = 1'b1;
      end
   endgenerate

   assign unused_lo = ^addr[1:0];
   assign hi        = addr[2];
   assign in_ch_win = upper_clear & (addr[9:8] != 2'b00);
   assign ch_idx    = addr[9:5] - CH_FIRST_SLOT;
   assign ch_sel    = ch_reg_e'(addr[4:3]);
   assign glb_hit   = upper_clear & ~in_ch_win;

   always_comb begin
      ch_hit = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (in_ch_win && (ch_idx == SLOT_W'(i)))
            ch_hit[i] = 1'b1;
      end
   end

   always_comb begin
      case (addr[7:3])
         5'h00:   glb_sel = G_CAP;
         5'h02:   glb_sel = G_CFG;
         5'h04:   glb_sel = G_STS;
         5'h1E:   glb_sel = G_CNT;
         default: glb_sel = G_HOLE;
      endcase
   end

endmodule

// File: rtl/evt_chan.sv
module evt_chan
   import evt_pkg::*;
#(
   parameter logic [31:0]      ROUTE_CAP = 32'h0,
   parameter logic [REG_W-1:0] CMP_INIT  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  ch_reg_e          sel,
   input  logic             hi,
   input  logic             wide,
   input  logic [REG_W-1:0] wdata,
   input  logic             fire,
   input  logic             glb_en,
   input  logic             sts_clr,
   output logic [REG_W-1:0] cfg_q,
   output logic [REG_W-1:0] cmp_q,
   output logic [REG_W-1:0] route_q,
   output logic             sts_q,
   output logic             irq
);

   localparam logic [REG_W-1:0] RO_BITS = {ROUTE_CAP, 32'd0} | (64'd1 << CB_CAP64);

   logic             lvl, ien, w32;
   logic             cfg_wr, cmp_wr, route_wr;
   logic [REG_W-1:0] cfg_d, cmp_d, route_d;
   logic             sts_d;
   logic             pulse_q;

   assign lvl = cfg_q[CB_LVL];
   assign ien = cfg_q[CB_IEN];
   assign w32 = cfg_q[CB_W32];

   assign cfg_wr   = wr_en && (sel == CH_CFG);
   assign cmp_wr   = wr_en && (sel == CH_CMP);
   assign route_wr = wr_en && (sel == CH_ROUTE);

   always_comb begin
      cfg_d = cfg_q;
      if (cfg_wr)
         cfg_d = keep_ro(merge64(cfg_q, wdata, hi, wide), cfg_q, CH_WMASK);

      cmp_d = cmp_q;
      if (cmp_wr) begin
         if (!w32)
            cmp_d = merge64(cmp_q, wdata, hi, wide);
         else if (!hi)
            cmp_d = {32'd0, wdata[HALF_W-1:0]};
      end
      if (cfg_wr && cfg_d[CB_W32])
         cmp_d = {32'd0, cmp_d[HALF_W-1:0]};

      route_d = route_wr ? merge64(route_q, wdata, hi, wide) : route_q;

      sts_d = sts_q;
      if (sts_clr)
         sts_d = 1'b0;
      if (cfg_wr && lvl && !cfg_d[CB_LVL])
         sts_d = 1'b0;
      if (fire)
         sts_d = lvl;   // level latches, edge leaves it clear
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= RO_BITS;
         cmp_q   <= CMP_INIT;
         route_q <= '0;
         sts_q   <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         cfg_q   <= cfg_d;
         cmp_q   <= cmp_d;
         route_q <= route_d;
         sts_q   <= sts_d;
         pulse_q <= fire & ~lvl & ien & glb_en;
      end
   end

   assign irq = (sts_q & lvl & ien & glb_en) | pulse_q;

endmodule

// File: rtl/evt_glb.sv
module evt_glb
   import evt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic             cnt_wr,
   input  logic             hi,
   input  logic             wide,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] cfg_q,
   output logic [REG_W-1:0] cnt_q,
   output logic             en
);

   assign en = cfg_q[GB_EN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         cnt_q <= '0;
      end else begin
         if (cfg_wr)
            cfg_q <= keep_ro(merge64(cfg_q, wdata, hi, wide), cfg_q, GLB_WMASK);
         if (cnt_wr)
            cnt_q <= merge64(cnt_q, wdata, hi, wide);
         else if (en)
            cnt_q <= cnt_q + 64'd1;
      end
   end

endmodule

// File: rtl/evt_regfile.sv
module evt_regfile
   import evt_pkg::*;
#(
   parameter int unsigned NUM_CH      = 3,
   parameter int unsigned ADDR_W      = 10,
   parameter logic [7:0]  REVISION    = 8'h01,
   parameter logic [31:0] TICK_PERIOD = 32'h0098_9680,
   parameter logic [31:0] ROUTE_CAP   = 32'h0000_0004
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic              bus_wide,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [63:0]       bus_wdata,
   output logic [63:0]       bus_rdata,
   input  logic [NUM_CH-1:0] ch_fire,
   output logic [NUM_CH-1:0] ch_irq
);

   localparam logic [REG_W-1:0] CAP_WORD =
      {TICK_PERIOD, 18'd0, 1'b1, 5'(NUM_CH - 1), REVISION};

   generate
      if (NUM_CH < 1 || NUM_CH > 24) begin : g_bad_num_ch
         $error("evt_regfile: NUM_CH must be 1..24");
      end
      if (ADDR_W < 10) begin : g_bad_addr_w
         $error("evt_regfile: ADDR_W must be at least 10");
      end
   endgenerate

   logic                        hi, glb_hit, wr_cyc;
   glb_reg_e                    glb_sel;
   ch_reg_e                     ch_sel;
   logic [NUM_CH-1:0]           ch_hit, sts_vec, clr_vec;
   logic [NUM_CH-1:0][REG_W-1:0] cfg_arr, cmp_arr, route_arr;
   logic [REG_W-1:0]            gcfg_q, cnt_q, sel_word;
   logic                        glb_en;

   assign wr_cyc  = bus_en & bus_we;
   assign clr_vec = (wr_cyc && glb_hit && (glb_sel == G_STS) && !hi) ?
                    bus_wdata[NUM_CH-1:0] : '0;

   evt_addr_dec #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
      .addr    (bus_addr),
      .hi      (hi),
      .glb_hit (glb_hit),
      .glb_sel (glb_sel),
      .ch_hit  (ch_hit),
      .ch_sel  (ch_sel)
   );

   evt_glb u_glb (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg_wr (wr_cyc && glb_hit && (glb_sel == G_CFG)),
      .cnt_wr (wr_cyc && glb_hit && (glb_sel == G_CNT)),
      .hi     (hi),
      .wide   (bus_wide),
      .wdata  (bus_wdata),
      .cfg_q  (gcfg_q),
      .cnt_q  (cnt_q),
      .en     (glb_en)
   );

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         evt_chan #(.ROUTE_CAP(ROUTE_CAP)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_cyc && ch_hit[i]),
            .sel     (ch_sel),
            .hi      (hi),
            .wide    (bus_wide),
            .wdata   (bus_wdata),
            .fire    (ch_fire[i]),
            .glb_en  (glb_en),
            .sts_clr (clr_vec[i]),
            .cfg_q   (cfg_arr[i]),
            .cmp_q   (cmp_arr[i]),
            .route_q (route_arr[i]),
            .sts_q   (sts_vec[i]),
            .irq     (ch_irq[i])
         );
      end
   endgenerate

   always_comb begin
      sel_word = '0;
      if (glb_hit) begin
         case (glb_sel)
            G_CAP:   sel_word = CAP_WORD;
            G_CFG:   sel_word = gcfg_q;
            G_STS:   sel_word = REG_W'(sts_vec);
            G_CNT:   sel_word = cnt_q;
            default: sel_word = '0;
         endcase
      end
      for (int i = 0; i < NUM_CH; i++) begin
         if (ch_hit[i]) begin
            case (ch_sel)
               CH_CFG:   sel_word = cfg_arr[i];
               CH_CMP:   sel_word = cmp_arr[i];
               CH_ROUTE: sel_word = route_arr[i];
               default:  sel_word = '0;
            endcase
         end
      end
   end

   assign bus_rdata = (bus_en && !bus_we) ?
                      (hi ? {32'd0, sel_word[REG_W-1:HALF_W]} : sel_word) : '0;

endmodule

// File: rtl/evt_regfile_chk.sv
module evt_regfile_chk
   import evt_pkg::*;
#(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned ADDR_W = 10
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         bus_en,
   input logic                         bus_we,
   input logic [ADDR_W-1:0]            bus_addr,
   input logic [63:0]                  bus_wdata,
   input logic [NUM_CH-1:0]            ch_fire,
   input logic [NUM_CH-1:0]            ch_irq,
   input logic [NUM_CH-1:0]            sts_vec,
   input logic [NUM_CH-1:0][REG_W-1:0] cfg_arr,
   input logic [NUM_CH-1:0][REG_W-1:0] cmp_arr,
   input logic                         glb_en,
   input logic [REG_W-1:0]             cnt_q
);

   logic sts_wr, cnt_wr, unused_chk;

   assign unused_chk = ^{cfg_arr, cmp_arr, bus_wdata};
   assign sts_wr = bus_en && bus_we && !bus_addr[2] &&
                   (bus_addr[ADDR_W-1:3] == (ADDR_W-3)'(4));
   assign cnt_wr = bus_en && bus_we &&
                   (bus_addr[ADDR_W-1:3] == (ADDR_W-3)'(30));

   // R9: frozen counter
   a_r9_frozen_count: assert property (@(posedge clk) disable iff (!rst_n)
      (!glb_en && !cnt_wr) |=> $stable(cnt_q));

   // R5: no line once the timer has been off for a full cycle
   a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!glb_en && !$past(glb_en)) |-> (ch_irq == '0));

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         a_r5_level_latch: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_fire[i] && cfg_arr[i][CB_LVL]) |=> sts_vec[i]);

         a_r4_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_wr && bus_wdata[i] && !ch_fire[i]) |=> !sts_vec[i]);

         a_r6_pending_drives_line: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_vec[i] && cfg_arr[i][CB_LVL] && cfg_arr[i][CB_IEN] && glb_en) |-> ch_irq[i]);

         a_r8_edge_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_arr[i][CB_LVL] && !$past(ch_fire[i])) |-> !ch_irq[i]);

         a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_arr[i][CB_W32] |-> (cmp_arr[i][63:32] == 32'd0));
      end
   endgenerate

endmodule

bind evt_regfile evt_regfile_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_en    (bus_en),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .ch_fire   (ch_fire),
   .ch_irq    (ch_irq),
   .sts_vec   (sts_vec),
   .cfg_arr   (cfg_arr),
   .cmp_arr   (cmp_arr),
   .glb_en    (glb_en),
   .cnt_q     (cnt_q)
);

// File: tb/evt_regfile_bench.sv
`timescale 1ns/1ps
module evt_regfile_bench;

   localparam int unsigned NUM_CH      = 4;
   localparam int unsigned ADDR_W      = 10;
   localparam logic [7:0]  REVISION    = 8'h01;
   localparam logic [31:0] TICK_PERIOD = 32'h0098_9680;
   localparam logic [31:0] ROUTE_CAP   = 32'h00F0_0A00;

   localparam logic [63:0] CAP   = {TICK_PERIOD, 18'd0, 1'b1, 5'(NUM_CH - 1), REVISION};
   localparam logic [63:0] RO_CH = {ROUTE_CAP, 32'd0} | 64'h20;
   localparam logic [63:0] ONES  = '1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_en = 1'b0, bus_we = 1'b0, bus_wide = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [63:0]       bus_wdata = '0;
   logic [63:0]       bus_rdata;
   logic [NUM_CH-1:0] ch_fire = '0;
   logic [NUM_CH-1:0] ch_irq;

   always #2 clk = ~clk;  // 250 MHz

   evt_regfile #(
      .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .REVISION(REVISION),
      .TICK_PERIOD(TICK_PERIOD), .ROUTE_CAP(ROUTE_CAP)
   ) u_evt_regfile (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .ch_fire(ch_fire), .ch_irq(ch_irq)
   );

   typedef struct {
      int unsigned cyc;
      bit          kind;   // 0 = read data, 1 = interrupt lines
      logic [63:0] exp;
      string       tag;
   } item_t;

   item_t       sb[$];
   int unsigned cyc_cnt = 0;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;
   item_t       cur;
   logic [63:0] act;

   always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

   // monitor: compare expectations due this cycle
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].cyc == cyc_cnt) begin
         cur = sb.pop_front();
         act = cur.kind ? 64'(ch_irq) : bus_rdata;
         checks++;
         if (act !== cur.exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", cur.tag, act, cur.exp);
         end
      end
   end

   function automatic logic [ADDR_W-1:0] cha(input int ch, input int sel);
      return ADDR_W'(32'h100 + ch * 32'h20 + sel * 8);
   endfunction

   task automatic idle();
      @(posedge clk); #1;
      bus_en = 1'b0; bus_we = 1'b0; ch_fire = '0;
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [63:0] d, input bit w);
      @(posedge clk); #1;
      bus_en = 1'b1; bus_we = 1'b1; bus_wide = w; bus_addr = a; bus_wdata = d; ch_fire = '0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, input logic [63:0] e, input string t);
      @(posedge clk); #1;
      bus_en = 1'b1; bus_we = 1'b0; bus_wide = 1'b1; bus_addr = a; ch_fire = '0;
      sb.push_back('{cyc: cyc_cnt, kind: 1'b0, exp: e, tag: t});
   endtask

   task automatic irq_is(input logic [NUM_CH-1:0] e, input string t);
      @(posedge clk); #1;
      bus_en = 1'b0; bus_we = 1'b0; ch_fire = '0;
      sb.push_back('{cyc: cyc_cnt, kind: 1'b1, exp: 64'(e), tag: t});
   endtask

   task automatic fire(input logic [NUM_CH-1:0] m);
      @(posedge clk); #1;
      bus_en = 1'b0; bus_we = 1'b0; ch_fire = m;
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      logic [63:0] x;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state and map
      rd(12'h000, CAP, "R1 capability");
      rd(12'h004, {32'd0, TICK_PERIOD}, "R1 capability upper half");
      rd(cha(0, 0), RO_CH, "R1 channel cfg reset");
      rd(cha(1, 1), ONES, "R1 comparator reset");
      rd(12'h010, 64'd0, "R1 global cfg reset");
      rd(12'h020, 64'd0, "R1 status reset");
      irq_is('0, "R1 lines low after reset");
      rd(cha(4, 0), 64'd0, "R1 channel past last reads zero");
      rd(cha(0, 3), 64'd0, "R1 channel hole reads zero");
      rd(12'h030, 64'd0, "R1 unmapped global reads zero");

      // R3 read-only protection
      wr(12'h000, ONES, 1'b1);
      rd(12'h000, CAP, "R3 capability write ignored");
      wr(cha(2, 0), ONES, 1'b1);
      rd(cha(2, 0), RO_CH | 64'h10E, "R3 channel cfg writable mask");
      rd(cha(2, 1), 64'h0000_0000_FFFF_FFFF, "R10 mode switch clears upper comparator");
      wr(cha(2, 0), 64'd0, 1'b1);
      rd(cha(2, 0), RO_CH, "R3 channel cfg clears to read-only bits");
      wr(12'h010, ONES, 1'b1);
      rd(12'h010, 64'd1, "R3 global cfg writable mask");
      wr(12'h010, 64'd0, 1'b1);

      // R2 width and halves on the route register
      wr(cha(1, 2), 64'h1111_2222_3333_4444, 1'b1);
      rd(cha(1, 2), 64'h1111_2222_3333_4444, "R2 8-byte write");
      wr(cha(1, 2) + 4, 64'hDEAD_BEEF_AAAA_BBBB, 1'b0);
      rd(cha(1, 2), 64'hAAAA_BBBB_3333_4444, "R2 upper-half merge");
      rd(cha(1, 2) + 4, 64'h0000_0000_AAAA_BBBB, "R2 read shifted by 32");
      wr(cha(1, 2), 64'hDEAD_BEEF_5555_6666, 1'b0);
      rd(cha(1, 2), 64'hAAAA_BBBB_5555_6666, "R2 lower-half merge");

      // R10 comparator in 32-bit mode
      wr(cha(3, 1), 64'h0123_4567_89AB_CDEF, 1'b1);
      rd(cha(3, 1), 64'h0123_4567_89AB_CDEF, "R10 64-bit comparator write");
      wr(cha(3, 0), 64'h100, 1'b0);
      rd(cha(3, 1), 64'h0000_0000_89AB_CDEF, "R10 upper cleared on mode set");
      wr(cha(3, 1) + 4, 64'h1234_5678, 1'b0);
      rd(cha(3, 1), 64'h0000_0000_89AB_CDEF, "R10 upper write ignored");
      wr(cha(3, 1), 64'hFFFF_0000_1234_0000, 1'b1);
      rd(cha(3, 1), 64'h0000_0000_1234_0000, "R10 wide write zero-extends");

      // R9 counter
      x = 64'h0000_0005_FFFF_FFFE;
      wr(12'h0F0, 64'h0000_0000_FFFF_FFFE, 1'b1);
      wr(12'h0F4, 64'h0000_0005, 1'b0);
      rd(12'h0F0, x, "R9 counter written in halves");
      rd(12'h0F0, x, "R9 counter frozen");
      wr(12'h010, 64'd1, 1'b0);
      rd(12'h0F0, x, "R9 counter first enabled cycle");
      rd(12'h0F0, x + 1, "R9 counter counts");
      rd(12'h0F0, x + 2, "R9 counter carries into upper half");
      wr(12'h010, 64'd0, 1'b0);
      rd(12'h0F0, x + 4, "R9 counter stops after disable");
      rd(12'h0F0, x + 4, "R9 counter holds");
      rd(12'h0F4, 64'd6, "R9 counter upper half");

      // R5, R6, R7 level mode
      wr(cha(0, 0), 64'h2, 1'b0);
      fire(4'b0001);
      irq_is(4'b0000, "R5 level status without enable keeps line low");
      rd(12'h020, 64'd1, "R5 level status latched while disabled");
      wr(cha(0, 0), 64'h6, 1'b0);
      irq_is(4'b0000, "R5 global off keeps line low");
      wr(12'h010, 64'd1, 1'b0);
      irq_is(4'b0001, "R6 global enable rise raises pending line");
      wr(cha(0, 0), 64'h2, 1'b0);
      irq_is(4'b0000, "R7 channel disable lowers line");
      rd(12'h020, 64'd1, "R7 channel disable keeps status");
      wr(cha(0, 0), 64'h6, 1'b0);
      irq_is(4'b0001, "R6 channel enable rise raises pending line");

      // R4 write-1-to-clear
      wr(12'h020, 64'h1, 1'b0);
      irq_is(4'b0000, "R4 clear drops line");
      rd(12'h020, 64'd0, "R4 status cleared");
      fire(4'b0001);
      wr(12'h020, 64'h2, 1'b0);
      rd(12'h020, 64'd1, "R4 zero bits leave status");
      wr(12'h024, 64'h1, 1'b0);
      rd(12'h020, 64'd1, "R4 upper-half write clears nothing");
      irq_is(4'b0001, "R4 line still high");

      // R7 level to edge
      wr(cha(0, 0), 64'h4, 1'b0);
      irq_is(4'b0000, "R7 level-to-edge lowers line");
      rd(12'h020, 64'd0, "R7 level-to-edge clears status");

      // R8 edge pulses
      fire(4'b0001);
      irq_is(4'b0001, "R8 edge pulse");
      irq_is(4'b0000, "R8 edge pulse lasts one cycle");
      rd(12'h020, 64'd0, "R8 edge leaves status clear");
      wr(cha(1, 0), 64'h0, 1'b0);
      fire(4'b0010);
      irq_is(4'b0000, "R8 disabled edge channel silent");

      // several level channels together
      wr(cha(1, 0), 64'h6, 1'b0);
      wr(cha(3, 0), 64'h106, 1'b0);
      fire(4'b1010);
      irq_is(4'b1010, "R6 two level channels raised");
      rd(12'h020, 64'hA, "R5 two status bits");
      wr(12'h010, 64'd0, 1'b0);
      irq_is(4'b0000, "R5 global disable lowers all");
      rd(12'h020, 64'hA, "R5 status kept over global disable");
      wr(12'h010, 64'd1, 1'b0);
      irq_is(4'b1010, "R6 global re-enable raises both");
      wr(12'h020, 64'hA, 1'b1);
      irq_is(4'b0000, "R4 wide clear drops both");
      rd(12'h020, 64'd0, "R4 wide clear status");

      idle();
      idle();
      idle();
      if (sb.size() != 0) begin
         checks++;
         errors++;
         $display("FAIL scoreboard left %0d items actual=%0d expected=0", sb.size(), sb.size());
      end
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

endmodule